// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Pin Controller

This block gathers three event strobes of a real-time clock (watchdog expiry, alarm match and power-fail detection) and latches each into its own sticky flag. Each flag is qualified by a per-source enable bit held in an 8-bit interrupt control register. A single interrupt pin is driven from the enabled flags. The pin can follow the flags as a level, or it can emit a fixed-length pulse. Its asserted polarity is also programmable.

A host reads the flags register through a one-cycle read strobe. That read returns the current flags on the same cycle and clears every flag on the following clock edge. If a pulse is in progress, the read also ends it early. The host can write and read back the control register at any time. Reset loads a control value that enables only the power-fail source, with pulse mode and an active-low pin.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the flags read as 0, the control register reads 8'h24, and the pin is high (inactive for active-low).
- R2: A one-cycle strobe on an event input sets its flag at the next clock edge. The flag stays set until a flags read. On `flags_rdata`, bit 2 is watchdog, bit 1 is alarm and bit 0 is power-fail.
- R3: While `flags_rd` is high, `flags_rdata` shows the current flags. On the next edge all flags clear.
- R4: An event strobe in the same cycle as a flags read leaves that flag set after the read.
- R5: Control bit 7 enables watchdog, bit 6 enables alarm and bit 5 enables power-fail. A set flag whose enable is 0 never asserts the pin.
- R6: In level mode (control bit 2 = 0), the pin is asserted while any enabled flag is set. It returns to inactive on the cycle after the read that clears the flag.
- R7: In pulse mode (control bit 2 = 1), an enabled event strobe asserts the pin for exactly PULSE_LEN cycles. The pulse starts on the cycle after the strobe.
- R8: A flags read during a pulse deasserts the pin on the next cycle.
- R9: An enabled event during an active pulse neither restarts nor extends the pulse.
- R10: Control bit 3 selects the polarity: 1 means active high and 0 means active low. Whenever the pin is not asserted, it drives the opposite level.
- R11: A control write stores the data. The reserved bits 4, 1 and 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wdog_evt | input | 1 | Watchdog expiry strobe |
| alarm_evt | input | 1 | Alarm match strobe |
| pfail_evt | input | 1 | Power-fail strobe |
| flags_rd | input | 1 | Host flags read strobe (clears flags) |
| ctl_wr | input | 1 | Host control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| flags_rdata | output | 3 | Flags: {watchdog, alarm, power-fail} |
| ctl_rdata | output | 8 | Control register read data |
| irq_pin | output | 1 | Interrupt output pin |

## Verification
The assertions check four behaviours on every cycle: flags are set by strobes and cleared by reads (including the collision case), the level-mode pin follows the enabled flags with the selected polarity, a pulse ends after a read, and the reserved control bits stay at zero. The exact pulse width, the non-restart of a pulse that is already running, and the power-on values can only be shown by the bench's directed scenarios, which count pin cycles and sample the register contents.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NSRC = 3;
  localparam int SRC_PF = 0;
  localparam int SRC_AL = 1;
  localparam int SRC_WD = 2;
  localparam logic [7:0] CTL_POR   = 8'h24;
  localparam logic [7:0] CTL_WMASK = 8'hEC;

  typedef struct packed {
    logic [NSRC-1:0] en;     // [7]=wdog [6]=alarm [5]=pfail
    logic            rsv4;
    logic            act_hi; // [3]
    logic            pulse;  // [2]
    logic [1:0]      rsv10;
  } ctl_t;
endpackage

// File: rtl/rtc_irq_rst_sync.sv
module rtc_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_ok,
  input  logic [N-1:0] evt,
  input  logic         rd,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_comb begin
      flag_d[i] = flag_q[i];
      if (rd)     flag_d[i] = 1'b0;
      if (evt[i]) flag_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) flag_q[i] <= 1'b0;
      else         flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/rtc_irq_ctl_reg.sv
module rtc_irq_ctl_reg
  import rtc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ok,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ctl_t       ctl_q
);
  ctl_t ctl_d;
  logic ctl_en;

  assign ctl_en = wr;
  assign ctl_d  = ctl_t'(wdata & CTL_WMASK);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     ctl_q <= ctl_t'(CTL_POR);
    else if (ctl_en) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_ok,
  input  logic trig,
  input  logic cut,
  output logic busy
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cut)              cnt_d = trig ? LOAD : '0;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else if (trig)        cnt_d = LOAD;
    else                  cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int PULSE_LEN = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdog_evt,
  input  logic       alarm_evt,
  input  logic       pfail_evt,
  input  logic       flags_rd,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [2:0] flags_rdata,
  output logic [7:0] ctl_rdata,
  output logic       irq_pin
);
  logic            rst_ok;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] flag_q;
  ctl_t            ctl_q;
  logic            trig, busy, asserted;

  assign evt[SRC_WD] = wdog_evt;
  assign evt[SRC_AL] = alarm_evt;
  assign evt[SRC_PF] = pfail_evt;

  rtc_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  rtc_irq_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_ok(rst_ok), .evt(evt), .rd(flags_rd), .flag_q(flag_q)
  );

  rtc_irq_ctl_reg u_ctl (
    .clk(clk), .rst_ok(rst_ok), .wr(ctl_wr), .wdata(ctl_wdata), .ctl_q(ctl_q)
  );

  assign trig = |(evt & ctl_q.en);

  rtc_irq_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_ok(rst_ok), .trig(trig), .cut(flags_rd), .busy(busy)
  );

  assign asserted    = ctl_q.pulse ? busy : |(flag_q & ctl_q.en);
  assign irq_pin     = asserted ? ctl_q.act_hi : ~ctl_q.act_hi;
  assign flags_rdata = flag_q;
  assign ctl_rdata   = ctl_q;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic [2:0] evt,
  input logic       flags_rd,
  input logic       ctl_wr,
  input logic [2:0] flags_rdata,
  input logic [7:0] ctl_rdata,
  input logic       irq_pin
);
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_ok)
    (evt != 3'b000) |=> ((flags_rdata & $past(evt)) == $past(evt))); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    (flags_rd && evt == 3'b000) |=> (flags_rdata == 3'b000)); // R3

  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_ok)
    (flags_rd && evt[0]) |=> flags_rdata[0]); // R4

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ctl_rdata[2]) |-> (irq_pin == (ctl_rdata[3] ^ ((flags_rdata & ctl_rdata[7:5]) == 3'b000)))); // R6

  AST_PULSE_CUT: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctl_rdata[2] && flags_rd && evt == 3'b000 && !ctl_wr) |=> (irq_pin != ctl_rdata[3])); // R8

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    ctl_wr |=> (ctl_rdata[4] == 1'b0 && ctl_rdata[1:0] == 2'b00)); // R11
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk(clk),
  .rst_ok(rst_ok),
  .evt({wdog_evt, alarm_evt, pfail_evt}),
  .flags_rd(flags_rd),
  .ctl_wr(ctl_wr),
  .flags_rdata(flags_rdata),
  .ctl_rdata(ctl_rdata),
  .irq_pin(irq_pin)
);

// File: tb/rtc_irq_ctrl_test.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_test;
  localparam int LEN = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wdog_evt, alarm_evt, pfail_evt, flags_rd, ctl_wr;
  logic [7:0] ctl_wdata;
  logic [2:0] flags_rdata;
  logic [7:0] ctl_rdata;
  logic       irq_pin;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rtc_irq_ctrl #(.PULSE_LEN(LEN)) uut (
    .clk(clk), .rst_n(rst_n), .wdog_evt(wdog_evt), .alarm_evt(alarm_evt),
    .pfail_evt(pfail_evt), .flags_rd(flags_rd), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .flags_rdata(flags_rdata), .ctl_rdata(ctl_rdata),
    .irq_pin(irq_pin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic evt(input logic [2:0] m);
    {wdog_evt, alarm_evt, pfail_evt} = m;
    @(negedge clk);
    {wdog_evt, alarm_evt, pfail_evt} = 3'b000;
  endtask

  task automatic rd_flags(input logic [2:0] expv, input string req);
    flags_rd = 1'b1;
    #1 check(flags_rdata == expv, req, flags_rdata, expv);
    @(negedge clk);
    flags_rd = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reset;
    check(flags_rdata == 3'b000, "R1", flags_rdata, 0);
    check(ctl_rdata == 8'h24, "R1", ctl_rdata, 8'h24);
    check(irq_pin == 1'b1, "R1", irq_pin, 1);
  endtask

  task automatic t_flags;
    wr_ctl(8'h00);
    evt(3'b100);
    check(flags_rdata == 3'b100, "R2", flags_rdata, 3'b100);
    check(irq_pin == 1'b1, "R5", irq_pin, 1);
    evt(3'b010);
    cyc(3);
    check(flags_rdata == 3'b110, "R2", flags_rdata, 3'b110);
    rd_flags(3'b110, "R3");
    check(flags_rdata == 3'b000, "R3", flags_rdata, 0);
  endtask

  task automatic t_collide;
    evt(3'b010);
    flags_rd = 1'b1; pfail_evt = 1'b1;
    @(negedge clk);
    flags_rd = 1'b0; pfail_evt = 1'b0;
    check(flags_rdata == 3'b001, "R4", flags_rdata, 3'b001);
    rd_flags(3'b001, "R4");
  endtask

  task automatic t_level;
    wr_ctl(8'h88);
    evt(3'b010);
    check(irq_pin == 1'b0, "R5", irq_pin, 0);
    evt(3'b100);
    check(irq_pin == 1'b1, "R6", irq_pin, 1);
    cyc(5);
    check(irq_pin == 1'b1, "R6", irq_pin, 1);
    rd_flags(3'b110, "R3");
    check(irq_pin == 1'b0, "R6", irq_pin, 0);
    wr_ctl(8'h80);
    check(irq_pin == 1'b1, "R10", irq_pin, 1);
    evt(3'b100);
    check(irq_pin == 1'b0, "R10", irq_pin, 0);
    rd_flags(3'b100, "R3");
  endtask

  task automatic t_pulse;
    int high = 0;
    wr_ctl(8'h2C);
    evt(3'b001);
    for (int i = 0; i < LEN + 4; i++) begin
      if (irq_pin) high++;
      @(negedge clk);
    end
    check(high == LEN, "R7", high, LEN);
    check(irq_pin == 1'b0, "R7", irq_pin, 0);
    rd_flags(3'b001, "R3");
  endtask

  task automatic t_no_restart;
    int high = 0;
    evt(3'b001);
    for (int i = 1; i <= LEN + 6; i++) begin
      if (irq_pin) high++;
      if (i == 3) pfail_evt = 1'b1;
      @(negedge clk);
      pfail_evt = 1'b0;
    end
    check(high == LEN, "R9", high, LEN);
    rd_flags(3'b001, "R3");
  endtask

  task automatic t_cut;
    wr_ctl(8'h24);
    evt(3'b001);
    cyc(2);
    check(irq_pin == 1'b0, "R10", irq_pin, 0);
    rd_flags(3'b001, "R3");
    check(irq_pin == 1'b1, "R8", irq_pin, 1);
    check(flags_rdata == 3'b000, "R8", flags_rdata, 0);
  endtask

  task automatic t_ctl;
    wr_ctl(8'hFF);
    check(ctl_rdata == 8'hEC, "R11", ctl_rdata, 8'hEC);
    wr_ctl(8'h13);
    check(ctl_rdata == 8'h00, "R11", ctl_rdata, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    {wdog_evt, alarm_evt, pfail_evt, flags_rd, ctl_wr} = '0;
    ctl_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset;
    t_flags;
    t_collide;
    t_level;
    t_pulse;
    t_no_restart;
    t_cut;
    t_ctl;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule